// File: doc/BRIEF.md
# Section-Based Partition Opcode Generator

A memory array whose columns are split into equal partitions by isolation switches can run one stateful gate per section in a single cycle. Each partition has its own column decoder, driven by a 3-bit opcode that says whether that partition applies the input voltages, the output voltage, both, or neither. This block removes the need to send those opcodes. It takes one compact control word and derives every partition's opcode. The word holds the three column indices local to a partition, one enable bit per partition, one isolation select per internal boundary, and a single direction bit.

The same local input-A, input-B and output index is forwarded to all partition decoders. A partition's opcode depends only on whether its left and right boundaries isolate, on the direction bit, and on its own enable. The block unpacks the word and registers the results. One cycle after a valid word, the partition decoders see a stable set of opcodes and indices. The sender is responsible for choosing a tight section division, in which no section could be split further.

Top module: `section_opcode_gen`

## Requirements
- R1: The control word is `3*IW + 2*N_PARTS` bits wide, where IW = log2(N_COLS/N_PARTS). Its fields, starting at bit 0, are:
  - input-A index in bits [IW-1:0];
  - input-B index in bits [2IW-1:IW];
  - output index in bits [3IW-1:2IW];
  - N_PARTS enable bits, with bit p belonging to partition p and partition 0 being the leftmost;
  - N_PARTS-1 boundary selects, with select i sitting between partitions i and i+1 and the value 1 meaning isolating;
  - the direction bit at the most significant position, where 0 means inputs left of outputs.
- R2: One cycle after a valid word, the three index outputs carry the word's input-A, input-B and output index fields. This single set is shared by all partitions.
- R3: Each partition's opcode is 3 bits: bit 2 enables input A, bit 1 enables input B and bit 0 enables the output. Partition p sits at opcode bits [3p+2:3p]. Bits 2 and 1 are always equal.
- R4: With direction 0, a partition's input bits are set when its left boundary isolates, and its output bit is set when its right boundary isolates.
- R5: With direction 1 the roles swap: the input bits follow the right boundary and the output bit follows the left boundary.
- R6: A partition whose enable bit is 0 receives opcode 000.
- R7: The missing left boundary of partition 0 and the missing right boundary of the last partition are both treated as isolating.
- R8: An enabled partition with both boundaries isolating receives opcode 111.
- R9: The outputs and `op_valid` update one cycle after `msg_valid`. After a cycle without a valid word, `op_valid` is 0 and all opcodes and indices are 0. Reset also clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Control word present this cycle |
| msg | input | 3*IW+2*N_PARTS | Packed control word |
| op_valid | output | 1 | Registered outputs hold a decoded word |
| idx_a | output | IW | Shared local input-A column index |
| idx_b | output | IW | Shared local input-B column index |
| idx_out | output | IW | Shared local output column index |
| part_ops | output | 3*N_PARTS | Per-partition opcodes, partition p at [3p+2:3p] |

## Verification
The bench builds the block with N_COLS=64 and N_PARTS=8. This gives a 3-bit index and a 25-bit word. With only 128 select patterns, random words hit both edge partitions, single-partition sections and long serial sections many times each. Directed table entries cover the fully parallel case, the fully serial case in both directions, paired sections and an all-disabled word. Their expected opcodes are worked out by hand. Random words are then compared against a model that reasons over a boundary list with sentinel ends.

// File: rtl/sec_opgen_pkg.sv
package sec_opgen_pkg;

  localparam int OP_W = 3;

  function automatic int idx_width(input int cols, input int parts);
    return $clog2(cols / parts);
  endfunction

  function automatic int word_width(input int cols, input int parts);
    return 3 * idx_width(cols, parts) + 2 * parts;
  endfunction

  // Opcode from the two boundary states: dir 0 places inputs on the
  // left edge of a section, dir 1 on the right edge.
  function automatic logic [OP_W-1:0] half_gate_op(input logic iso_left,
                                                   input logic iso_right,
                                                   input logic dir,
                                                   input logic enable);
    logic drive_in;
    logic drive_out;
    drive_in  = dir ? iso_right : iso_left;
    drive_out = dir ? iso_left  : iso_right;
    return {drive_in & enable, drive_in & enable, drive_out & enable};
  endfunction

endpackage

// File: rtl/sec_word_unpack.sv
module sec_word_unpack #(
  parameter int IW      = 5,
  parameter int N_PARTS = 32,
  localparam int WORD_W = 3 * IW + 2 * N_PARTS
) (
  input  logic [WORD_W-1:0]  word,
  output logic [IW-1:0]      f_ina,
  output logic [IW-1:0]      f_inb,
  output logic [IW-1:0]      f_out,
  output logic [N_PARTS-1:0] f_en,
  output logic [N_PARTS-2:0] f_sel,
  output logic               f_dir
);
  localparam int EN_LSB  = 3 * IW;
  localparam int SEL_LSB = EN_LSB + N_PARTS;

  always_comb begin
    f_ina = word[IW-1:0];
    f_inb = word[2*IW-1:IW];
    f_out = word[3*IW-1:2*IW];
    f_en  = word[SEL_LSB-1:EN_LSB];
    f_sel = word[WORD_W-2:SEL_LSB];
    f_dir = word[WORD_W-1];
  end
endmodule

// File: rtl/sec_part_slice.sv
module sec_part_slice
  import sec_opgen_pkg::*;
(
  input  logic            iso_left,
  input  logic            iso_right,
  input  logic            dir,
  input  logic            enable,
  output logic [OP_W-1:0] op
);
  always_comb op = half_gate_op(iso_left, iso_right, dir, enable);
endmodule

// File: rtl/section_opcode_gen.sv
module section_opcode_gen
  import sec_opgen_pkg::*;
#(
  parameter int N_COLS  = 1024,
  parameter int N_PARTS = 32,
  localparam int IW     = idx_width(N_COLS, N_PARTS),
  localparam int WORD_W = word_width(N_COLS, N_PARTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    msg_valid,
  input  logic [WORD_W-1:0]       msg,
  output logic                    op_valid,
  output logic [IW-1:0]           idx_a,
  output logic [IW-1:0]           idx_b,
  output logic [IW-1:0]           idx_out,
  output logic [OP_W*N_PARTS-1:0] part_ops
);
  logic [IW-1:0]           w_ina, w_inb, w_out;
  logic [N_PARTS-1:0]      w_en;
  logic [N_PARTS-2:0]      w_sel;
  logic                    w_dir;
  logic [N_PARTS:0]        boundary_iso;   // boundary b sits left of partition b
  logic [OP_W*N_PARTS-1:0] next_ops;

  sec_word_unpack #(.IW(IW), .N_PARTS(N_PARTS)) u_unpack (
    .word(msg), .f_ina(w_ina), .f_inb(w_inb), .f_out(w_out),
    .f_en(w_en), .f_sel(w_sel), .f_dir(w_dir)
  );

  // Array edges act as isolating boundaries (R7)
  always_comb boundary_iso = {1'b1, w_sel, 1'b1};

  for (genvar p = 0; p < N_PARTS; p++) begin : g_part
    sec_part_slice u_slice (
      .iso_left (boundary_iso[p]),
      .iso_right(boundary_iso[p+1]),
      .dir      (w_dir),
      .enable   (w_en[p]),
      .op       (next_ops[OP_W*p +: OP_W])
    );

    assert_inputs_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      part_ops[OP_W*p+2] == part_ops[OP_W*p+1]);

    assert_disabled_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !w_en[p]) |=> (part_ops[OP_W*p +: OP_W] == 3'b000));

    assert_lone_section_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && w_en[p] && boundary_iso[p] && boundary_iso[p+1])
        |=> (part_ops[OP_W*p +: OP_W] == 3'b111));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !msg_valid) begin
      op_valid <= 1'b0;
      idx_a    <= '0;
      idx_b    <= '0;
      idx_out  <= '0;
      part_ops <= '0;
    end else begin
      op_valid <= 1'b1;
      idx_a    <= w_ina;
      idx_b    <= w_inb;
      idx_out  <= w_out;
      part_ops <= next_ops;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (op_valid == $past(msg_valid)));

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (part_ops == '0 && idx_a == '0 && idx_b == '0 && idx_out == '0));

  assert_shared_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> (idx_a == $past(msg[IW-1:0]) && idx_out == $past(msg[3*IW-1:2*IW])));

endmodule

// File: tb/test_section_opcode_gen.sv
module test_section_opcode_gen;
  localparam int NC = 64;
  localparam int NP = 8;
  localparam int IW = 3;
  localparam int WW = 3 * IW + 2 * NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 1'b0;
  logic [WW-1:0] msg = '0;
  logic op_valid;
  logic [IW-1:0] idx_a, idx_b, idx_out;
  logic [3*NP-1:0] part_ops;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  section_opcode_gen #(.N_COLS(NC), .N_PARTS(NP)) i_section_opcode_gen (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg(msg),
    .op_valid(op_valid), .idx_a(idx_a), .idx_b(idx_b), .idx_out(idx_out),
    .part_ops(part_ops)
  );

  // Directed table: selects, enables, direction, hand-derived opcodes
  localparam logic [6:0]  T_SEL [5] = '{7'h7F, 7'h00, 7'h00, 7'h7F, 7'h2A};
  localparam logic [7:0]  T_EN  [5] = '{8'hFF, 8'h81, 8'h81, 8'h00, 8'hFF};
  localparam logic        T_DIR [5] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [23:0] T_EXP [5] = '{24'hFFFFFF, 24'h200006, 24'hC00001,
                                        24'h000000, 24'h38E38E};

  function automatic logic [WW-1:0] pack(input logic [2:0] a, input logic [2:0] b,
                                         input logic [2:0] o, input logic [7:0] en,
                                         input logic [6:0] sel, input logic dir);
    return {dir, sel, en, o, b, a};
  endfunction

  // Model: list of boundaries 0..NP with both ends fixed isolating
  function automatic logic [3*NP-1:0] model(input logic [6:0] sel,
                                            input logic [7:0] en, input logic dir);
    logic [NP:0] bnd;
    logic [3*NP-1:0] r;
    r = '0;
    bnd[0] = 1'b1;
    bnd[NP] = 1'b1;
    for (int i = 1; i < NP; i++) bnd[i] = sel[i-1];
    for (int p = 0; p < NP; p++) begin
      logic side_in, side_out;
      side_in  = (dir == 1'b0) ? bnd[p] : bnd[p+1];
      side_out = (dir == 1'b0) ? bnd[p+1] : bnd[p];
      if (en[p]) r[3*p +: 3] = {side_in, side_in, side_out};
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [WW-1:0] w, input logic v);
    @(negedge clk);
    msg = w;
    msg_valid = v;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset valid", {31'd0, op_valid}, 32'd0);
    chk("R9 reset opcodes", {8'd0, part_ops}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R4 R5 R6 R7 R8 with R2 indices
    for (int i = 0; i < 5; i++) begin
      logic [2:0] a, b, o;
      a = 3'(i); b = 3'(i + 1); o = 3'(i + 2);
      send(pack(a, b, o, T_EN[i], T_SEL[i], T_DIR[i]), 1'b1);
      chk("R4/R5/R6/R7/R8 table opcodes", {8'd0, part_ops}, {8'd0, T_EXP[i]});
      chk("R2 shared indices", {23'd0, idx_a, idx_b, idx_out}, {23'd0, a, b, o});
      chk("R9 valid after word", {31'd0, op_valid}, 32'd1);
    end

    // R7: serial section, edge partitions alone enabled, direction 1
    send(pack(3'd7, 3'd7, 3'd0, 8'h81, 7'h00, 1'b1), 1'b1);
    chk("R7 edges dir1", {8'd0, part_ops}, 32'h00C00001);
    // R8: single-partition section in the middle (partition 3)
    send(pack(3'd1, 3'd1, 3'd4, 8'h08, 7'b0001100, 1'b0), 1'b1);
    chk("R8 lone middle partition", {8'd0, part_ops}, 32'h00000E00);

    // R9: idle cycle clears outputs
    send(pack(3'd5, 3'd6, 3'd7, 8'hFF, 7'h7F, 1'b0), 1'b0);
    chk("R9 idle valid", {31'd0, op_valid}, 32'd0);
    chk("R9 idle opcodes", {8'd0, part_ops}, 32'd0);
    chk("R9 idle indices", {23'd0, idx_a, idx_b, idx_out}, 32'd0);

    // Random words against the model: R1 R3 R4 R5 R6
    for (int n = 0; n < 300; n++) begin
      logic [2:0] a, b, o;
      logic [7:0] en;
      logic [6:0] sel;
      logic dir;
      logic [23:0] exp;
      a = 3'($urandom); b = 3'($urandom); o = 3'($urandom);
      en = 8'($urandom); sel = 7'($urandom); dir = 1'($urandom);
      exp = model(sel, en, dir);
      send(pack(a, b, o, en, sel, dir), 1'b1);
      chk("R1 random word opcodes", {8'd0, part_ops}, {8'd0, exp});
      chk("R2 random indices", {23'd0, idx_a, idx_b, idx_out}, {23'd0, a, b, o});
      for (int p = 0; p < NP; p++)
        if (part_ops[3*p+2] !== part_ops[3*p+1])
          chk("R3 input bits equal", {31'd0, part_ops[3*p+2]}, {31'd0, part_ops[3*p+1]});
    end

    // Reset in mid-stream clears outputs (R9)
    send(pack(3'd1, 3'd2, 3'd3, 8'hFF, 7'h7F, 1'b0), 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R9 reset clears", {7'd0, op_valid, part_ops}, 32'd0);
    finish_run();
  end
endmodule